// File: doc/BRIEF.md
# Signed Binary to Packed Decimal Converter

This block turns a 128-bit two's-complement integer into a 128-bit signed packed-decimal word. The word holds a sign code in its lowest nibble and 31 decimal digits above it, least significant digit first. The block also returns a four-bit condition code that classifies the result as negative, positive or zero, or that flags a magnitude too large for 31 digits.

A caller presents the operand and a preferred-sign select bit together with a one-cycle start strobe. The block takes the absolute value of the whole 128-bit operand and checks it against the largest 31-digit number. It then feeds the magnitude, most significant bit first, through a shift-and-add-3 digit register at one bit per clock. When every bit has been consumed, it registers the packed result and the condition code and raises a one-cycle done strobe. Both stay on the outputs until the next conversion finishes. A start that arrives while a conversion is running is dropped.

Top module: `sq2bcd_convert`

## Requirements
- R1: The result holds the sign code in bits [3:0]. Decimal digit k, for k = 1 to 31, sits in bits [4k+3:4k], with digit 1 the least significant. Every digit nibble is in the range 0 to 9.
- R2: A negative operand gets sign code 0xD.
- R3: A non-negative operand gets sign code 0xC when the select bit sampled with start is 0, and 0xF when it is 1.
- R4: The magnitude of a negative operand is the two's complement of all 128 bits taken as one number. An all-ones operand converts to digit 1 = 1 with every other digit 0.
- R5: An operand whose magnitude is above 10^31-1 is an overflow. This covers the most negative 128-bit value and values whose upper 64 bits alone look in range. On overflow the condition code is 0001 (only SO set) and the digits carry no meaning.
- R6: The condition code bits are [3]=LT, [2]=GT, [1]=EQ and [0]=SO. Without overflow SO is 0 and exactly one of the others is set: LT for a nonzero negative value, GT for a nonzero positive value.
- R7: A zero operand gives all-zero digits, the positive sign code chosen by the select bit, and condition code 0010 (EQ).
- R8: Done is high for exactly one cycle, 128 rising clock edges after the edge that accepts start, and at no other time. Result and condition code are valid in that cycle.
- R9: A start pulse that arrives while a conversion is running has no effect. The running conversion finishes on time with the result of the first operand.
- R10: While reset is asserted, done is 0 and the result and condition code are all zero.
- R11: The extreme values +(10^31-1) and -(10^31-1) convert to 31 nines without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| operand_i | input | 128 | Signed two's-complement operand, sampled with start |
| pref_sel_i | input | 1 | Selects the positive sign code (0: 0xC, 1: 0xF), sampled with start |
| result_o | output | 128 | Packed decimal result: sign nibble plus 31 digits |
| cc_o | output | 4 | Condition code {LT, GT, EQ, SO} |
| done_o | output | 1 | One-cycle strobe marking a new result |

## Verification
Every result is due exactly 128 rising edges after the edge that accepts start. Done, the packed word and the condition code all change together on that edge. The bench model counts the same edges from each accepted start, ignores starts while its own count is running, and compares done on every falling edge. It compares the result and the condition code on the falling edge where it expects done, so the comparison never depends on the order of processes at the clock edge. The digits are not compared for overflow cases, because the requirements leave them undefined.

// File: rtl/sq2bcd_pkg.sv
package sq2bcd_pkg;

   // condition code bit positions
   localparam int CC_LT = 3;
   localparam int CC_GT = 2;
   localparam int CC_EQ = 1;
   localparam int CC_SO = 0;

   typedef logic [3:0] nibble_t;

endpackage

// File: rtl/sq2bcd_magnitude.sv
module sq2bcd_magnitude #(
   parameter int IN_W = 128,
   parameter int NDIG = 31
) (
   input  logic [IN_W-1:0] op_i,
   output logic [IN_W-1:0] mag_o,
   output logic            neg_o,
   output logic            ovf_o
);

   // largest magnitude that fits in NDIG decimal digits
   function automatic logic [IN_W-1:0] max_mag();
      logic [IN_W-1:0] v;
      v = IN_W'(1);
      for (int i = 0; i < NDIG; i++) begin
         v = v * IN_W'(10);
      end
      return v - IN_W'(1);
   endfunction

   localparam logic [IN_W-1:0] LIMIT = max_mag();

   if (NDIG * 10 > IN_W * 3) begin : g_chk_fit
      $error("sq2bcd_magnitude: digit limit does not fit the operand width");
   end

   always_comb begin
      neg_o = op_i[IN_W-1];
      // full-width negate, never per half
      mag_o = neg_o ? (~op_i + IN_W'(1)) : op_i;
      ovf_o = (mag_o > LIMIT);
   end

endmodule

// File: rtl/sq2bcd_dabble_step.sv
module sq2bcd_dabble_step #(
   parameter int NDIG = 31
) (
   input  logic [NDIG*4-1:0] bcd_i,
   input  logic              bit_i,
   output logic [NDIG*4-1:0] bcd_o
);

   localparam int DW = NDIG * 4;

   logic [DW-1:0] adj;

   // correct each digit that would reach 10 or more after doubling
   for (genvar d = 0; d < NDIG; d++) begin : g_dig
      assign adj[d*4 +: 4] = (bcd_i[d*4 +: 4] > 4'd4) ? (bcd_i[d*4 +: 4] + 4'd3)
                                                       : bcd_i[d*4 +: 4];
   end

   assign bcd_o = {adj[DW-2:0], bit_i};

endmodule

// File: rtl/sq2bcd_encode.sv
module sq2bcd_encode
   import sq2bcd_pkg::*;
#(
   parameter int          NDIG     = 31,
   parameter logic [3:0]  SGN_NEG  = 4'hD,
   parameter logic [3:0]  SGN_POS0 = 4'hC,
   parameter logic [3:0]  SGN_POS1 = 4'hF
) (
   input  logic [NDIG*4-1:0] digits_i,
   input  logic              neg_i,
   input  logic              ovf_i,
   input  logic              pref_i,
   output logic [NDIG*4+3:0] result_o,
   output logic [3:0]        cc_o
);

   logic [NDIG-1:0] dig_nz;
   nibble_t         sgn;
   logic            all_zero;

   for (genvar d = 0; d < NDIG; d++) begin : g_nz
      assign dig_nz[d] = |digits_i[d*4 +: 4];
   end

   always_comb begin
      all_zero = ~|dig_nz;
      if (neg_i) begin
         sgn = SGN_NEG;
      end else if (pref_i) begin
         sgn = SGN_POS1;
      end else begin
         sgn = SGN_POS0;
      end
      result_o = {digits_i, sgn};

      cc_o = '0;
      if (ovf_i) begin
         cc_o[CC_SO] = 1'b1;
      end else if (all_zero) begin
         cc_o[CC_EQ] = 1'b1;
      end else if (neg_i) begin
         cc_o[CC_LT] = 1'b1;
      end else begin
         cc_o[CC_GT] = 1'b1;
      end
   end

endmodule

// File: rtl/sq2bcd_convert.sv
module sq2bcd_convert
   import sq2bcd_pkg::*;
#(
   parameter int          IN_W     = 128,
   parameter int          NDIG     = 31,
   parameter logic [3:0]  SGN_NEG  = 4'hD,
   parameter logic [3:0]  SGN_POS0 = 4'hC,
   parameter logic [3:0]  SGN_POS1 = 4'hF
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  start_i,
   input  logic [IN_W-1:0]       operand_i,
   input  logic                  pref_sel_i,
   output logic [(NDIG+1)*4-1:0] result_o,
   output logic [3:0]            cc_o,
   output logic                  done_o
);

   localparam int RES_W = (NDIG + 1) * 4;
   localparam int DW    = NDIG * 4;
   localparam int CNT_W = $clog2(IN_W + 1);

   if (IN_W < 8) begin : g_chk_width
      $error("sq2bcd_convert: operand width too small");
   end
   if (SGN_NEG == SGN_POS0 || SGN_NEG == SGN_POS1) begin : g_chk_sign
      $error("sq2bcd_convert: negative sign code must differ from positive codes");
   end
   if (NDIG < 1) begin : g_chk_dig
      $error("sq2bcd_convert: need at least one digit");
   end

   logic [IN_W-1:0]  mag_w;
   logic             neg_w;
   logic             ovf_w;
   logic [IN_W-1:0]  mag_q;
   logic             neg_q;
   logic             ovf_q;
   logic             pref_q;
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DW-1:0]    bcd_q;
   logic [DW-1:0]    bcd_nxt;
   logic [RES_W-1:0] enc_res;
   logic [3:0]       enc_cc;

   sq2bcd_magnitude #(
      .IN_W (IN_W),
      .NDIG (NDIG)
   ) u_mag (
      .op_i  (operand_i),
      .mag_o (mag_w),
      .neg_o (neg_w),
      .ovf_o (ovf_w)
   );

   sq2bcd_dabble_step #(
      .NDIG (NDIG)
   ) u_step (
      .bcd_i (bcd_q),
      .bit_i (mag_q[IN_W-1]),
      .bcd_o (bcd_nxt)
   );

   sq2bcd_encode #(
      .NDIG     (NDIG),
      .SGN_NEG  (SGN_NEG),
      .SGN_POS0 (SGN_POS0),
      .SGN_POS1 (SGN_POS1)
   ) u_enc (
      .digits_i (bcd_nxt),
      .neg_i    (neg_q),
      .ovf_i    (ovf_q),
      .pref_i   (pref_q),
      .result_o (enc_res),
      .cc_o     (enc_cc)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mag_q    <= '0;
         neg_q    <= 1'b0;
         ovf_q    <= 1'b0;
         pref_q   <= 1'b0;
         busy_q   <= 1'b0;
         cnt_q    <= '0;
         bcd_q    <= '0;
         result_o <= '0;
         cc_o     <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (busy_q) begin
            bcd_q <= bcd_nxt;
            mag_q <= {mag_q[IN_W-2:0], 1'b0};
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
               busy_q   <= 1'b0;
               done_o   <= 1'b1;
               result_o <= enc_res;
               cc_o     <= enc_cc;
            end
         end else if (start_i) begin
            mag_q  <= mag_w;
            neg_q  <= neg_w;
            ovf_q  <= ovf_w;
            pref_q <= pref_sel_i;
            bcd_q  <= '0;
            cnt_q  <= CNT_W'(IN_W);
            busy_q <= 1'b1;
         end
      end
   end

   // ---------------- assertions ----------------
   logic [NDIG-1:0] dig_ok;
   for (genvar d = 0; d < NDIG; d++) begin : g_dec_chk
      assign dig_ok[d] = (result_o[(d+1)*4 +: 4] <= 4'd9);
   end

   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R8

   AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && cnt_q != CNT_W'(1)) |=> (busy_q && !done_o)); // R9

   AST_SO_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && cc_o[CC_SO]) |-> (cc_o[3:1] == 3'b000)); // R5

   AST_ONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !cc_o[CC_SO]) |-> ($countones(cc_o[3:1]) == 1)); // R6

   AST_NEG_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && cc_o[CC_LT]) |-> (result_o[3:0] == SGN_NEG)); // R2

   AST_POS_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !cc_o[CC_LT] && !cc_o[CC_SO])
         |-> (result_o[3:0] == (pref_q ? SGN_POS1 : SGN_POS0))); // R3

   AST_ZERO_DIGITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && cc_o[CC_EQ]) |-> (result_o[RES_W-1:4] == '0)); // R7

   AST_DECIMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !cc_o[CC_SO]) |-> (&dig_ok)); // R1

endmodule

// File: tb/sq2bcd_convert_tb.sv
`timescale 1ns/1ps
module sq2bcd_convert_tb;

   localparam int IN_W  = 128;
   localparam int NDIG  = 31;
   localparam int RES_W = 128;

   logic             clk   = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             pref  = 1'b0;
   logic [IN_W-1:0]  op    = '0;
   logic [RES_W-1:0] res;
   logic [3:0]       cc;
   logic             done;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   sq2bcd_convert u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .start_i    (start),
      .operand_i  (op),
      .pref_sel_i (pref),
      .result_o   (res),
      .cc_o       (cc),
      .done_o     (done)
   );

   task automatic check(input string req, input logic [RES_W-1:0] act, input logic [RES_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // behavioural expectation from the requirements
   function automatic void ref_conv(input logic [IN_W-1:0] v, input logic p,
                                    output logic [RES_W-1:0] r, output logic [3:0] c,
                                    output logic o);
      logic [IN_W-1:0] m;
      logic [IN_W-1:0] q;
      logic [IN_W-1:0] lim;
      lim = 1;
      for (int i = 0; i < NDIG; i++) lim = lim * 10;
      lim = lim - 1;
      m = v[IN_W-1] ? -v : v;
      o = (m > lim);
      r = '0;
      r[3:0] = v[IN_W-1] ? 4'hD : (p ? 4'hF : 4'hC);
      q = m;
      for (int k = 1; k <= NDIG; k++) begin
         r[k*4 +: 4] = 4'(q % 10);
         q = q / 10;
      end
      if (o)               c = 4'b0001;
      else if (m == 0)     c = 4'b0010;
      else if (v[IN_W-1])  c = 4'b1000;
      else                 c = 4'b0100;
   endfunction

   // cycle model: counts edges from each accepted start
   int               m_rem  = 0;
   logic             m_done = 1'b0;
   logic [RES_W-1:0] m_res  = '0;
   logic [3:0]       m_cc   = '0;
   logic             m_ovf  = 1'b0;
   string            m_tag  = "";
   string            cur_tag = "";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rem  = 0;
         m_done = 1'b0;
      end else begin
         m_done = 1'b0;
         if (m_rem > 0) begin
            m_rem--;
            if (m_rem == 0) m_done = 1'b1;
         end else if (start) begin
            ref_conv(op, pref, m_res, m_cc, m_ovf);
            m_tag = cur_tag;
            m_rem = IN_W;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check("R8 done strobe timing", RES_W'(done), RES_W'(m_done));
         if (m_done) begin
            check({m_tag, " condition code (R6 encoding)"}, RES_W'(cc), RES_W'(m_cc));
            if (!m_ovf) check({m_tag, " packed result"}, res, m_res);
         end
      end
   end

   task automatic run_case(input logic [IN_W-1:0] v, input logic p, input string tag, input bit poke);
      @(negedge clk);
      op = v; pref = p; cur_tag = tag; start = 1'b1;
      @(negedge clk);
      start = 1'b0; op = '0;
      if (poke) begin
         repeat (10) @(negedge clk);
         op = 128'd99; pref = ~p; start = 1'b1;
         @(negedge clk);
         start = 1'b0; op = '0;
      end
      repeat (IN_W + 4) @(negedge clk);
   endtask

   logic [IN_W-1:0] big;

   initial begin
      big = 1;
      for (int i = 0; i < NDIG; i++) big = big * 10;
      big = big - 1;

      repeat (3) @(negedge clk);
      check("R10 reset done", RES_W'(done), '0);
      check("R10 reset result", res, '0);
      check("R10 reset cc", RES_W'(cc), '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_case('0, 1'b0, "R7 zero select 0", 1'b0);
      run_case('0, 1'b1, "R7 zero select 1", 1'b0);
      run_case(128'd1, 1'b0, "R6 plus one GT", 1'b0);
      run_case(128'd42, 1'b0, "R3 positive select 0", 1'b0);
      run_case({64'd1, 64'd0}, 1'b1, "R3 upper word only select 1", 1'b0);
      run_case({128{1'b1}}, 1'b0, "R4 all-ones magnitude", 1'b0);
      run_case(-{64'd1, 64'd0}, 1'b1, "R4 negative spanning halves", 1'b0);
      run_case(128'd1234567890123456789012345, 1'b1, "R1 digit placement", 1'b0);
      run_case(-128'd987654321, 1'b0, "R2 negative sign code", 1'b0);
      run_case(big, 1'b0, "R11 largest positive", 1'b0);
      run_case(-big, 1'b1, "R11 largest negative", 1'b0);
      run_case(big + 1, 1'b0, "R5 one above limit", 1'b0);
      run_case(-(big + 1), 1'b0, "R5 one below negative limit", 1'b0);
      run_case({1'b1, 127'd0}, 1'b0, "R5 most negative", 1'b0);
      run_case({1'b0, {127{1'b1}}}, 1'b1, "R5 most positive", 1'b0);
      run_case({64'h0000_007E_37BE_2022, 64'hFFFF_FFFF_FFFF_FFFF}, 1'b0,
               "R5 low word pushes over", 1'b0);
      run_case(128'd12345, 1'b0, "R9 start while busy", 1'b1);
      run_case(-128'd7, 1'b1, "R2 small negative", 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule